// File: doc/BRIEF.md
# Condition code update unit

This block holds the 8-bit flag register of a small processor that works on both 8-bit and 16-bit data. After each data operation the datapath presents an operation class, an operand-size select, the result value and the adder's carry, half-carry and overflow outputs. When the write strobe is high, the block computes the new negative, zero, overflow, carry and half-carry flags from these inputs and stores them on the next clock edge. All other register bits are left as they are.

The class decides which flags move. Arithmetic classes take carry and overflow from the adder. Load and store classes test the moved value, force overflow to zero and keep carry and half-carry. A clear behaves like subtracting an operand from itself: the result is zero and there is no borrow, so the flags take fixed values. The no-effect class, and any unused class code, leaves the register untouched. For a 16-bit operation, negative comes from the top result bit, zero tests the whole word, and half-carry is kept.

Top module: `ccu_update`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `cc_q` becomes 0x00 on that edge.
- R2: When `wr_en` is low at a rising clock edge and `rst_n` is high, `cc_q` keeps its value.
- R3: For the classes load (1), store (2), add (4) and subtract (5), bit 3 (N) takes result bit 7 when `wide` is 0, and result bit 15 when `wide` is 1.
- R4: For those same classes, bit 2 (Z) is set exactly when result bits 7..0 are all zero (when `wide` is 0), or when all 16 result bits are zero (when `wide` is 1). Result bits 15..8 have no effect on an 8-bit operation.
- R5: For add (4) and subtract (5), bit 1 (V) takes `ovf_in` and bit 0 (C) takes `carry_in`. When `wide` is 0, bit 5 (H) takes `half_in`.
- R6: For add and subtract with `wide` = 1, bit 5 (H) keeps its value and `half_in` has no effect.
- R7: For load (1) and store (2), bit 1 (V) becomes 0, and bits 0 (C) and 5 (H) keep their values whatever the adder inputs are.
- R8: For clear (3), bit 2 (Z) becomes 1, and bits 3 (N), 1 (V) and 0 (C) become 0. Bit 5 (H) keeps its value. The result and adder inputs have no effect.
- R9: For the no-effect class (0) and the unused codes 6 and 7, `cc_q` keeps its value even when `wr_en` is high.
- R10: Bits 7, 6 and 4 of `cc_q` are never changed by a write, so after reset they stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; the register updates only when it is high |
| op_class | input | 3 | Operation class: 0 none, 1 load, 2 store, 3 clear, 4 add, 5 subtract |
| wide | input | 1 | Operand size: 0 = 8-bit, 1 = 16-bit |
| result | input | 16 | Result value of the operation |
| carry_in | input | 1 | Carry or borrow out of the adder |
| half_in | input | 1 | Carry out of bit 3 of the adder |
| ovf_in | input | 1 | Signed overflow from the adder |
| cc_q | output | 8 | Registered flag register |

## Verification
The bench builds the block with its default parameters: a 16-bit result split into two 8-bit lanes. This is the smallest setting in which the size select matters. The sweep covers all eight class codes, both sizes, every combination of the three adder flags, and a set of result words: walking ones, zero, all ones, values with only the low byte zero and values with only the high byte zero. This reaches every path by which a flag is set, kept or forced. Because each step starts from whatever flags the previous step left, stores and clears are checked against many different prior carry and half-carry states. Runs with the strobe low and a reset in mid-sequence cover the hold and reset paths.

// File: rtl/ccu_pkg.sv
// Package: shared constants and types for the condition code update unit.
// Assumes an 8-bit flag register with fixed flag positions.
package ccu_pkg;

    localparam int CC_W  = 8;
    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_H = 5;

    // Class codes; 6 and 7 are unused and act as no-effect.
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_CLEAR = 3'd3,
        OP_ADD   = 3'd4,
        OP_SUB   = 3'd5
    } op_class_e;

endpackage

// File: rtl/ccu_result_probe.sv
// Module: derives the sign and zero indications of a result.
// Assumes DATA_W is a whole multiple of NARROW_W. Lane 0 is the narrow
// operand, and a wide operand spans all lanes.
module ccu_result_probe #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              wide_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              msb_o,
    output logic              zero_o
);
    localparam int LANES = DATA_W / NARROW_W;

    logic [LANES-1:0] lane_zero;

    // Per-lane zero detect, one reduction per lane.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_zero[g] = ~|result_i[g*NARROW_W +: NARROW_W];
        end
    endgenerate

    // Pick the sign bit and the zero test that match the operand size.
    always_comb begin
        if (wide_i) begin
            msb_o  = result_i[DATA_W-1];
            zero_o = &lane_zero;
        end else begin
            msb_o  = result_i[NARROW_W-1];
            zero_o = lane_zero[0];
        end
    end
endmodule

// File: rtl/ccu_flag_select.sv
// Module: combinational next-value selection for the flag register.
// Assumes the probe outputs are already sized to the operand. Bits other
// than N, Z, V, C and H always pass through from cur_i.
module ccu_flag_select
    import ccu_pkg::*;
(
    input  logic [2:0]      op_i,
    input  logic            wide_i,
    input  logic            msb_i,
    input  logic            zero_i,
    input  logic            carry_i,
    input  logic            half_i,
    input  logic            ovf_i,
    input  logic [CC_W-1:0] cur_i,
    output logic [CC_W-1:0] nxt_o
);
    // Apply the flag effects of the operation class onto the current value.
    always_comb begin
        nxt_o = cur_i;
        case (op_i)
            OP_LOAD, OP_STORE: begin
                nxt_o[POS_N] = msb_i;
                nxt_o[POS_Z] = zero_i;
                nxt_o[POS_V] = 1'b0;
            end
            OP_CLEAR: begin
                nxt_o[POS_N] = 1'b0;
                nxt_o[POS_Z] = 1'b1;
                nxt_o[POS_V] = 1'b0;
                nxt_o[POS_C] = 1'b0;
            end
            OP_ADD, OP_SUB: begin
                nxt_o[POS_N] = msb_i;
                nxt_o[POS_Z] = zero_i;
                nxt_o[POS_V] = ovf_i;
                nxt_o[POS_C] = carry_i;
                if (!wide_i) begin
                    nxt_o[POS_H] = half_i;
                end
            end
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ccu_update.sv
// Module: top of the condition code update unit. It holds the flag register
// and writes it on a strobed clock edge. Reset is synchronous and active-low.
// Assumes the adder flags are valid in the same cycle as the result.
module ccu_update
    import ccu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        op_class,
    input  logic              wide,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_in,
    input  logic              half_in,
    input  logic              ovf_in,
    output logic [CC_W-1:0]   cc_q
);
    logic            res_msb;
    logic            res_zero;
    logic [CC_W-1:0] cc_nxt;

    ccu_result_probe #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) probe_i (
        .wide_i   (wide),
        .result_i (result),
        .msb_o    (res_msb),
        .zero_o   (res_zero)
    );

    ccu_flag_select sel_i (
        .op_i    (op_class),
        .wide_i  (wide),
        .msb_i   (res_msb),
        .zero_i  (res_zero),
        .carry_i (carry_in),
        .half_i  (half_in),
        .ovf_i   (ovf_in),
        .cur_i   (cc_q),
        .nxt_o   (cc_nxt)
    );

    // Flag register: clear on reset, load the selected value on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
        end else if (wr_en) begin
            cc_q <= cc_nxt;
        end
    end
endmodule

// File: rtl/ccu_update_chk.sv
// Module: assertion checker for ccu_update, attached with bind below.
// Assumes the default 8/16-bit lane split for the sign-bit checks.
module ccu_update_chk
    import ccu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      op_class,
    input logic            wide,
    input logic [15:0]     result,
    input logic            carry_in,
    input logic            half_in,
    input logic            ovf_in,
    input logic [CC_W-1:0] cc_q
);
    logic nz_class;
    logic ar_class;
    logic mv_class;
    assign mv_class = (op_class == OP_LOAD) || (op_class == OP_STORE);
    assign ar_class = (op_class == OP_ADD) || (op_class == OP_SUB);
    assign nz_class = mv_class || ar_class;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> cc_q == 8'h00);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cc_q));

    assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && nz_class) |=>
        cc_q[POS_N] == ($past(wide) ? $past(result[15]) : $past(result[7])));

    assert_arith_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ar_class) |=>
        (cc_q[POS_C] == $past(carry_in)) && (cc_q[POS_V] == $past(ovf_in)));

    assert_wide_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ar_class && wide) |=> $stable(cc_q[POS_H]));

    assert_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mv_class) |=>
        !cc_q[POS_V] && $stable(cc_q[POS_C]) && $stable(cc_q[POS_H]));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_class == OP_CLEAR) |=>
        (cc_q[3:0] == 4'b0100) && $stable(cc_q[POS_H]));

    assert_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nz_class && op_class != OP_CLEAR) |=> $stable(cc_q));

    assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cc_q[7:6] == 2'b00) && !cc_q[4]);
endmodule

bind ccu_update ccu_update_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .op_class (op_class),
    .wide     (wide),
    .result   (result),
    .carry_in (carry_in),
    .half_in  (half_in),
    .ovf_in   (ovf_in),
    .cc_q     (cc_q)
);

// File: tb/ccu_update_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps class codes, sizes, adder flags and result patterns, and
// compares the register with a model written from the requirements.
module ccu_update_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] result = 16'h0;
    logic        carry_in = 1'b0;
    logic        half_in = 1'b0;
    logic        ovf_in = 1'b0;
    logic [7:0]  cc_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    ccu_update dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_class(op_class),
        .wide(wide), .result(result), .carry_in(carry_in),
        .half_in(half_in), .ovf_in(ovf_in), .cc_q(cc_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input int i);
        if (i < 16) return 16'h1 << i;
        case (i)
            16: return 16'h0000;
            17: return 16'hFFFF;
            18: return 16'h00FF;
            19: return 16'hFF00;
            20: return 16'h7FFF;
            21: return 16'h8001;
            22: return 16'h7F7F;
            default: return 16'h5A3C;
        endcase
    endfunction

    // Model: next flag value written from the requirements alone.
    function automatic logic [7:0] predict(input logic [7:0] cur, input logic [2:0] op,
                                           input logic w, input logic [15:0] r,
                                           input logic c, input logic h, input logic v);
        logic [7:0] nx = cur;
        logic sgn = w ? r[15] : r[7];
        logic zer = w ? (r == 16'h0) : (r[7:0] == 8'h0);
        case (op)
            3'd1, 3'd2: begin nx[3] = sgn; nx[2] = zer; nx[1] = 1'b0; end
            3'd3: begin nx[3] = 1'b0; nx[2] = 1'b1; nx[1] = 1'b0; nx[0] = 1'b0; end
            3'd4, 3'd5: begin
                nx[3] = sgn; nx[2] = zer; nx[1] = v; nx[0] = c;
                if (!w) nx[5] = h;
            end
            default: nx = cur;
        endcase
        return nx;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic w);
        case (op)
            3'd1, 3'd2: return "R7 (with R3/R4)";
            3'd3: return "R8";
            3'd4, 3'd5: return w ? "R6 (with R3/R4/R5)" : "R5 (with R3/R4)";
            default: return "R9";
        endcase
    endfunction

    task automatic step(input logic we, input logic [2:0] op, input logic w,
                        input logic [15:0] r, input logic c, input logic h, input logic v);
        @(negedge clk);
        wr_en = we; op_class = op; wide = w; result = r;
        carry_in = c; half_in = h; ovf_in = v;
        if (we) model = predict(model, op, w, r, c, h, v);
        @(negedge clk);
        if (we) begin
            check(tag_of(op, w), cc_q, model);
            check("R3 N bit", {7'd0, cc_q[3]}, {7'd0, model[3]});
            check("R4 Z bit", {7'd0, cc_q[2]}, {7'd0, model[2]});
        end else begin
            check("R2 strobe low", cc_q, model);
        end
        check("R10 fixed bits", {cc_q[7:6], cc_q[4]} , 3'b000);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset value", cc_q, 8'h00);
        rst_n = 1'b1;

        // Full sweep; flag state carried across steps varies prior C/H.
        for (int op = 0; op < 8; op++) begin
            for (int w = 0; w < 2; w++) begin
                for (int p = 0; p < 24; p++) begin
                    for (int f = 0; f < 8; f++) begin
                        step(1'b1, op[2:0], w[0], pattern(p), f[0], f[1], f[2]);
                    end
                end
            end
        end

        // Arithmetic with all flags set, then moves and clear over it.
        step(1'b1, 3'd5, 1'b0, 16'h0080, 1'b1, 1'b1, 1'b1);
        step(1'b1, 3'd2, 1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0); // R4 upper byte ignored
        step(1'b1, 3'd1, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0); // R7 keeps C, H
        step(1'b1, 3'd4, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b0); // R6 H kept
        step(1'b1, 3'd3, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1); // R8

        // Strobe low across all classes.
        for (int op = 0; op < 8; op++) begin
            step(1'b0, op[2:0], 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1);
        end

        // Reset from a non-zero state.
        step(1'b1, 3'd4, 1'b0, 16'h0080, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; op_class = 3'd4;
        @(negedge clk);
        check("R1 mid-run reset", cc_q, 8'h00);
        rst_n = 1'b1;
        wr_en = 1'b0;
        model = 8'h00;
        step(1'b1, 3'd0, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule